// File: doc/BRIEF.md
# DMA Controller Command, Mask and Status Port

This block holds the control register set of a four-channel DMA controller. Software reaches it through one 8-bit I/O window: a 3-bit offset selects one of eight write actions and, for reads, one of two readable registers. The block stores the following state:

- a command byte;
- a 4-bit channel mask;
- an 8-bit status word, with the terminal-count flags in the low nibble and the request flags in the high nibble;
- one mode byte per channel.

The channel sequencers report terminal count by pulsing `tc_set`. Devices raise and drop their requests through `hreq_hold` and `hreq_release`. The block moves no data. It exports its registers to the channel logic and pulses `ff_clr`, which clears the byte-order flip-flop shared by the channel address and count registers.

Several writes have side effects. A command value that contains any unsupported bit is dropped. Reading status returns the whole word and then clears only the terminal-count nibble. A master-reset write, and the asynchronous power-on reset, both leave all channels masked with status and command cleared.

Top module: `dmac_ctrl_port`

## Requirements
- R1: A write at offset 0 loads `command` only when the data is 8'h00 or 8'h04. Any other value leaves `command` unchanged.
- R2: A write at offset 1 uses data[1:0] as the channel number `c`. Data bit 2 is copied into status bit 4+c, and status bit c is cleared. Both changes appear after the clock edge.
- R3: A write at offset 2 sets mask bit data[1:0] when data bit 2 is 1 and clears it when data bit 2 is 0. The other mask bits keep their values.
- R4: A write at offset 3 stores the whole data byte as the mode byte of channel data[1:0]. The mode byte of channel n is `mode_all[8n+7:8n]`. Its fields are: [3:2] transfer type, [4] auto-init, [5] address decrement, [7:6] operating mode.
- R5: `ff_clr` is high in the same cycle as a write at offset 4 or offset 5, and low in every other cycle.
- R6: A write at offset 5 makes `chan_mask` 4'hF, `status` 8'h00 and `command` 8'h00 after the clock edge. This overrides `tc_set`, hold, release and read-clear in that cycle. Mode bytes are not changed.
- R7: A write at offset 6 clears all mask bits. A write at offset 7 loads `chan_mask` from data[3:0].
- R8: `rdata` is combinational and is 0 while `rd_en` is low. With `rd_en` high, offset 0 returns `status`, offset 1 returns {4'b0, `chan_mask`}, and offsets 2 to 7 return 8'h00.
- R9: A read at offset 0 clears status bits [3:0] after the clock edge and leaves bits [7:4] unchanged.
- R10: A `tc_set[n]` pulse sets status bit n after the edge. This wins over a read-clear and over an offset-1 clear of that bit in the same cycle.
- R11: `hreq_hold[n]` sets status bit 4+n and `hreq_release[n]` clears it. If both are high, hold wins. Both override an offset-1 write to the same bit in the same cycle.
- R12: While `rst_n` is low, the state is the master-reset state of R6, and every mode byte is 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_en | input | 1 | Write strobe for the offset on `addr` |
| rd_en | input | 1 | Read strobe for the offset on `addr` |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| tc_set | input | 4 | Terminal-count pulses from the channel sequencers |
| hreq_hold | input | 4 | Hardware request raise, one per channel |
| hreq_release | input | 4 | Hardware request drop, one per channel |
| ff_clr | output | 1 | Clear pulse for the shared byte flip-flop |
| command | output | 8 | Command register |
| chan_mask | output | 4 | Channel mask, 1 = masked |
| status | output | 8 | [7:4] request flags, [3:0] terminal-count flags |
| mode_all | output | 32 | Mode bytes of all four channels, channel 0 in the low byte |

## Verification
Directed sequences first try the command filter with the one accepted non-zero value, two rejected values and zero. This shows whether the filter keys on single bits or on the whole byte. The status word is then driven with colliding events in the same cycle: terminal count against read-clear, terminal count against an offset-1 clear, hold against release, and hold against a clearing request write. Each collision separates the intended priority from the reverse one. A long seeded random mix of all eight write offsets, both read paths and random channel pulses is then compared cycle by cycle against a bench model, which exposes wrong channel selection, unwanted changes to neighbouring bits and missing side effects.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int OFS_CMD   = 0;
  localparam int OFS_REQ   = 1;
  localparam int OFS_MSK1  = 2;
  localparam int OFS_MODE  = 3;
  localparam int OFS_FFCLR = 4;
  localparam int OFS_MRST  = 5;
  localparam int OFS_MCLR  = 6;
  localparam int OFS_MALL  = 7;
  localparam int ROFS_STAT = 0;
  localparam int ROFS_MASK = 1;
  // Command bits that may be set without the write being dropped.
  localparam logic [7:0] CMD_ALLOWED = 8'h04;
endpackage

// File: rtl/dmac_cmd_reg.sv
module dmac_cmd_reg #(
  parameter int unsigned     DW      = 8,
  parameter logic [DW-1:0]   ALLOWED = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          mrst,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cmd
);
  logic [DW-1:0] cmd_q, cmd_n;
  logic          accept, en;

  // Zero also passes: it has no bit outside the allowed set.
  assign accept = (wdata & ~ALLOWED) == '0;
  assign en     = mrst | (wr & accept);

  always_comb begin
    cmd_n = cmd_q;
    if (wr && accept) cmd_n = wdata;
    if (mrst)         cmd_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cmd_q <= '0;
    else if (en) cmd_q <= cmd_n;
  end

  assign cmd = cmd_q;
endmodule

// File: rtl/dmac_mask_reg.sv
module dmac_mask_reg #(
  parameter int unsigned NCH  = 4,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_one,
  input  logic            wr_clr,
  input  logic            wr_all,
  input  logic            mrst,
  input  logic [CH_W-1:0] sel,
  input  logic            flag,
  input  logic [NCH-1:0]  all_val,
  output logic [NCH-1:0]  mask
);
  logic [NCH-1:0] mask_q, mask_n, sel_oh;
  logic           en;

  assign sel_oh = {{(NCH-1){1'b0}}, 1'b1} << sel;
  assign en     = wr_one | wr_clr | wr_all | mrst;

  always_comb begin
    mask_n = mask_q;
    if (wr_one) mask_n = flag ? (mask_q | sel_oh) : (mask_q & ~sel_oh);
    if (wr_clr) mask_n = '0;
    if (wr_all) mask_n = all_val;
    if (mrst)   mask_n = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '1;
    else if (en) mask_q <= mask_n;
  end

  assign mask = mask_q;
endmodule

// File: rtl/dmac_status_reg.sv
module dmac_status_reg #(
  parameter int unsigned NCH  = 4,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_clr,
  input  logic             req_wr,
  input  logic [CH_W-1:0]  sel,
  input  logic             flag,
  input  logic             mrst,
  input  logic [NCH-1:0]   tc_set,
  input  logic [NCH-1:0]   hold,
  input  logic [NCH-1:0]   rel,
  output logic [2*NCH-1:0] status
);
  logic [NCH-1:0] tc_q, tc_n, rq_q, rq_n, sel_oh;
  logic           en;

  assign sel_oh = {{(NCH-1){1'b0}}, 1'b1} << sel;
  assign en     = rd_clr | req_wr | mrst | (|tc_set) | (|hold) | (|rel);

  // Priority, lowest first: read-clear, request write, hardware
  // release, hardware hold, terminal count, master reset.
  always_comb begin
    tc_n = tc_q;
    rq_n = rq_q;
    if (rd_clr) tc_n = '0;
    if (req_wr) begin
      tc_n = tc_n & ~sel_oh;
      rq_n = (rq_n & ~sel_oh) | (sel_oh & {NCH{flag}});
    end
    rq_n = (rq_n & ~rel) | hold;
    tc_n = tc_n | tc_set;
    if (mrst) begin
      tc_n = '0;
      rq_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= '0;
      rq_q <= '0;
    end else if (en) begin
      tc_q <= tc_n;
      rq_q <= rq_n;
    end
  end

  assign status = {rq_q, tc_q};
endmodule

// File: rtl/dmac_mode_bank.sv
module dmac_mode_bank #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned DW   = 8,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CH_W-1:0]   sel,
  input  logic [DW-1:0]     wdata,
  output logic [NCH*DW-1:0] mode_all
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] mode_q;
    logic          en;

    assign en = wr && (sel == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mode_q <= '0;
      else if (en) mode_q <= wdata;
    end

    assign mode_all[g*DW +: DW] = mode_q;
  end
endmodule

// File: rtl/dmac_ctrl_port.sv
module dmac_ctrl_port
  import dmac_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NCH-1:0]    tc_set,
  input  logic [NCH-1:0]    hreq_hold,
  input  logic [NCH-1:0]    hreq_release,
  output logic              ff_clr,
  output logic [DW-1:0]     command,
  output logic [NCH-1:0]    chan_mask,
  output logic [2*NCH-1:0]  status,
  output logic [NCH*DW-1:0] mode_all
);
  localparam int unsigned CH_W = $clog2(NCH);
  localparam int unsigned NOFS = 2 ** AW;

  logic [NOFS-1:0] wr_hit;
  logic [CH_W-1:0] sel;
  logic            flag, rd_stat;

  always_comb begin
    for (int k = 0; k < NOFS; k++) wr_hit[k] = wr_en && (addr == AW'(k));
  end

  assign sel     = wdata[CH_W-1:0];
  assign flag    = wdata[CH_W];
  assign rd_stat = rd_en && (addr == AW'(ROFS_STAT));
  assign ff_clr  = wr_hit[OFS_FFCLR] | wr_hit[OFS_MRST];

  dmac_cmd_reg #(.DW(DW), .ALLOWED(DW'(CMD_ALLOWED))) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(wr_hit[OFS_CMD]), .mrst(wr_hit[OFS_MRST]),
    .wdata(wdata), .cmd(command)
  );

  dmac_mask_reg #(.NCH(NCH)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_one(wr_hit[OFS_MSK1]), .wr_clr(wr_hit[OFS_MCLR]),
    .wr_all(wr_hit[OFS_MALL]), .mrst(wr_hit[OFS_MRST]), .sel(sel), .flag(flag),
    .all_val(wdata[NCH-1:0]), .mask(chan_mask)
  );

  dmac_status_reg #(.NCH(NCH)) u_stat (
    .clk(clk), .rst_n(rst_n), .rd_clr(rd_stat), .req_wr(wr_hit[OFS_REQ]),
    .sel(sel), .flag(flag), .mrst(wr_hit[OFS_MRST]), .tc_set(tc_set),
    .hold(hreq_hold), .rel(hreq_release), .status(status)
  );

  dmac_mode_bank #(.NCH(NCH), .DW(DW)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr(wr_hit[OFS_MODE]), .sel(sel),
    .wdata(wdata), .mode_all(mode_all)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == AW'(ROFS_STAT))      rdata[2*NCH-1:0] = status;
      else if (addr == AW'(ROFS_MASK)) rdata[NCH-1:0]   = chan_mask;
    end
  end
endmodule

// File: rtl/dmac_ctrl_port_chk.sv
module dmac_ctrl_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [2:0]  addr,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic [3:0]  tc_set,
  input logic [3:0]  hreq_hold,
  input logic [3:0]  hreq_release,
  input logic        ff_clr,
  input logic [7:0]  command,
  input logic [3:0]  chan_mask,
  input logic [7:0]  status,
  input logic [31:0] mode_all
);
  logic mrst;
  assign mrst = wr_en && addr == 3'd5;

  a_r1_cmd_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && wdata != 8'h00 && wdata != 8'h04) |=> $stable(command));

  a_r2_req_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && hreq_hold == 4'd0 && hreq_release == 4'd0)
    |=> status[4 + $past(wdata[1:0])] == $past(wdata[2]));

  a_r3_mask_one: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2) |=> chan_mask[$past(wdata[1:0])] == $past(wdata[2]));

  a_r4_mode_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3) |=> mode_all[$past(wdata[1:0]) * 8 +: 8] == $past(wdata));

  a_r5_ff_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ff_clr |-> (wr_en && (addr == 3'd4 || addr == 3'd5)));

  a_r6_master: assert property (@(posedge clk) disable iff (!rst_n)
    mrst |=> (chan_mask == 4'hF && status == 8'h00 && command == 8'h00));

  a_r7_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd7) |=> chan_mask == $past(wdata[3:0]));

  a_r8_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || addr >= 3'd2) |-> rdata == 8'h00);

  a_r9_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd0 && tc_set == 4'd0) |=> status[3:0] == 4'd0);

  a_r10_tc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((|tc_set) && !mrst) |=> (status[3:0] & $past(tc_set)) == $past(tc_set));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hreq_hold) && !mrst) |=> (status[7:4] & $past(hreq_hold)) == $past(hreq_hold));

  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(hreq_release & ~hreq_hold)) && !mrst)
    |=> (status[7:4] & $past(hreq_release & ~hreq_hold)) == 4'd0);
endmodule

bind dmac_ctrl_port dmac_ctrl_port_chk u_chk (.*);

// File: tb/tb_dmac_ctrl_port.sv
module tb_dmac_ctrl_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  addr;
  logic [7:0]  wdata, rdata;
  logic [3:0]  tc_set, hreq_hold, hreq_release;
  logic        ff_clr;
  logic [7:0]  command;
  logic [3:0]  chan_mask;
  logic [7:0]  status;
  logic [31:0] mode_all;

  always #4 clk = ~clk;

  dmac_ctrl_port dut (.*);

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] m_cmd, m_st;
  logic [3:0] m_mask;
  logic [7:0] m_mode [4];
  string      prev_tag = "R12";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cmd = 8'h00; m_mask = 4'hF; m_st = 8'h00;
  endtask

  task automatic cmp_state(string tag);
    chk({tag, " command"}, command, m_cmd);
    chk({tag, " mask"}, chan_mask, m_mask);
    chk({tag, " status"}, status, m_st);
    for (int c = 0; c < 4; c++) chk({tag, " mode"}, mode_all[c*8 +: 8], m_mode[c]);
  endtask

  function automatic logic [7:0] exp_rd(logic r, logic [2:0] a);
    if (!r) return 8'h00;
    if (a == 3'd0) return m_st;
    if (a == 3'd1) return {4'h0, m_mask};
    return 8'h00;
  endfunction

  task automatic model_step(logic w, logic r, logic [2:0] a, logic [7:0] d,
                            logic [3:0] tc, logic [3:0] ho, logic [3:0] re);
    logic [3:0] lo, hi, oh;
    lo = m_st[3:0]; hi = m_st[7:4];
    oh = 4'b0001 << d[1:0];
    if (r && a == 3'd0) lo = 4'h0;
    if (w) begin
      case (a)
        3'd0: if (d == 8'h00 || d == 8'h04) m_cmd = d;
        3'd1: begin lo = lo & ~oh; hi = d[2] ? (hi | oh) : (hi & ~oh); end
        3'd2: m_mask = d[2] ? (m_mask | oh) : (m_mask & ~oh);
        3'd3: m_mode[d[1:0]] = d;
        3'd6: m_mask = 4'h0;
        3'd7: m_mask = d[3:0];
        default: ;
      endcase
    end
    hi = (hi & ~re) | ho;
    lo = lo | tc;
    m_st = {hi, lo};
    if (w && a == 3'd5) begin
      model_reset();
    end
  endtask

  task automatic cyc(string tag, logic w, logic r, logic [2:0] a, logic [7:0] d,
                     logic [3:0] tc = 4'h0, logic [3:0] ho = 4'h0, logic [3:0] re = 4'h0);
    @(negedge clk);
    cmp_state(prev_tag);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    tc_set = tc; hreq_hold = ho; hreq_release = re;
    #1;
    chk({tag, " rdata"}, rdata, exp_rd(r, a));
    chk({"R5 ff_clr under ", tag}, ff_clr, w && (a == 3'd4 || a == 3'd5));
    model_step(w, r, a, d, tc, ho, re);
    prev_tag = tag;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    tc_set = 0; hreq_hold = 0; hreq_release = 0;
    model_reset();
    for (int c = 0; c < 4; c++) m_mode[c] = 8'h00;
    repeat (3) @(negedge clk);
    cmp_state("R12 reset");                       // R12
    rst_n = 1'b1;

    // R1: command filter
    cyc("R1", 1, 0, 3'd0, 8'h04);
    cyc("R1", 1, 0, 3'd0, 8'h05);
    cyc("R1", 1, 0, 3'd0, 8'h80);
    cyc("R1", 1, 0, 3'd0, 8'h00);
    // R4: modes
    cyc("R4", 1, 0, 3'd3, 8'hA5);
    cyc("R4", 1, 0, 3'd3, 8'h5A);
    cyc("R4", 1, 0, 3'd3, 8'hFF);
    // R3 and R7: masks
    cyc("R3", 1, 0, 3'd2, 8'h00);
    cyc("R3", 1, 0, 3'd2, 8'h01);
    cyc("R7", 1, 0, 3'd6, 8'hFF);
    cyc("R3", 1, 0, 3'd2, 8'h07);
    cyc("R7", 1, 0, 3'd7, 8'hF5);
    cyc("R8", 0, 1, 3'd1, 8'h00);
    // R2: request writes
    cyc("R2", 1, 0, 3'd1, 8'h06);
    cyc("R2", 1, 0, 3'd1, 8'h05);
    cyc("R2", 1, 0, 3'd1, 8'h02);
    // R10 and R9: terminal count against clears
    cyc("R10", 0, 0, 3'd0, 8'h00, 4'b1111);
    cyc("R10", 0, 1, 3'd0, 8'h00, 4'b0011);
    cyc("R9", 0, 1, 3'd0, 8'h00);
    cyc("R9", 0, 1, 3'd0, 8'h00);
    cyc("R10", 1, 0, 3'd1, 8'h01, 4'b0010);
    // R11: hold and release
    cyc("R11", 0, 0, 3'd0, 8'h00, 4'h0, 4'b0100, 4'b0100);
    cyc("R11", 0, 0, 3'd0, 8'h00, 4'h0, 4'b0000, 4'b0100);
    cyc("R11", 1, 0, 3'd1, 8'h03, 4'h0, 4'b1000, 4'b0000);
    cyc("R11", 1, 0, 3'd1, 8'h07, 4'h0, 4'b0000, 4'b1000);
    cyc("R9", 0, 1, 3'd0, 8'h00);
    // R8: unreadable offsets
    for (int a = 2; a < 8; a++) cyc("R8", 0, 1, 3'(a), 8'h00);
    cyc("R8", 0, 0, 3'd0, 8'h00);
    // R5 and R6
    cyc("R5", 1, 0, 3'd4, 8'h00);
    cyc("R6", 1, 0, 3'd5, 8'h00, 4'hF, 4'hF, 4'h0);
    cyc("R8", 0, 1, 3'd1, 8'h00);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic       w, r;
      logic [7:0] d;
      string      t;
      a = 3'($urandom_range(0, 7));
      w = ($urandom_range(0, 9) < 7);
      if (a == 3'd5 && $urandom_range(0, 3) != 0) w = 1'b0;
      r = ($urandom_range(0, 3) == 0);
      d = 8'($urandom);
      if (a == 3'd0 && $urandom_range(0, 1) == 1) d = ($urandom_range(0, 1) == 1) ? 8'h04 : 8'h00;
      case (a)
        3'd0: t = w ? "R1" : "R9";
        3'd1: t = w ? "R2" : "R8";
        3'd2: t = w ? "R3" : "R8";
        3'd3: t = w ? "R4" : "R8";
        3'd4: t = "R5";
        3'd5: t = w ? "R6" : "R8";
        default: t = w ? "R7" : "R8";
      endcase
      cyc(t, w, r, a, d,
          ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0,
          ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0,
          ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0);
    end
    cyc("R11", 0, 0, 3'd0, 8'h00);
    @(negedge clk);
    cmp_state(prev_tag);
    finish_run();
  end
endmodule